// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Responder

This block collects interrupt requests from a row of device-side cells and presents them to a processor as a single request line. Each device connects to its own cell. A short pulse on the device's request input is captured and held in that cell. The processor sees one level, `irq`, which is the OR of every held request.

When the processor answers with an acknowledge, the acknowledge enters the cell at index 0 and ripples toward higher indices within the same cycle. A cell that holds no request passes it on unchanged. The first cell that holds a request absorbs the acknowledge, drives its own identifier onto the shared vector bus and signals its device that it has been served. It then drops its held request at the next clock edge.

The identifier of cell `i` is `VEC_BASE + i`, so the processor can jump straight to the right service routine without polling each device. An acknowledge that reaches the far end of the chain unclaimed is reported on `ack_tail`.

Top module: `irq_chain`

## Requirements
- R1: `irq` is high in a cycle exactly when at least one cell holds a captured request; a device request pulse first shows on `irq` in the cycle after the clock edge that samples it.
- R2: While `int_ack` is high, exactly the lowest-indexed cell holding a request is granted (`dev_granted` bit `i` high for cell `i`); cells at higher indices see no acknowledge.
- R3: In a granted cycle `vec_out` equals `VEC_BASE + i` (width `VW`) for the granted cell `i`, and `vec_valid` is high.
- R4: When no cell is granted, `vec_out` is all zeros and `vec_valid` is low; in particular the bus is never driven while `int_ack` is low.
- R5: `ack_tail` is high exactly when `int_ack` is high and no cell holds a request.
- R6: A captured request stays held across any number of cycles until that cell is granted, even after the device request returns low.
- R7: A granted cell releases its held request at the end of the grant cycle unless its device requests again in that same cycle.
- R8: A device request sampled in the same cycle as an acknowledge is not eligible for that acknowledge; it is held and served by a later one.
- R9: Synchronous active-low reset clears every held request, so `irq`, `vec_valid`, `dev_granted` and `vec_out` are all zero after reset.
- R10: At most one bit of `dev_granted` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_req | input | N | Request pulse or level from each device; bit i belongs to cell i |
| int_ack | input | 1 | Acknowledge from the processor, enters cell 0 |
| irq | output | 1 | Shared request line, OR of all held requests |
| vec_out | output | VW | Identifier of the granted cell, zero when none |
| vec_valid | output | 1 | High when some cell drives `vec_out` |
| dev_granted | output | N | One-hot grant back to the devices |
| ack_tail | output | 1 | Acknowledge that left the last cell unclaimed |

## Verification
Assertions check several properties on every clock cycle:
- a grant only occurs under an acknowledge;
- at most one cell is granted;
- the vector bus is idle without a grant;
- an acknowledge reaching the tail coincides with an empty chain;
- a held request survives every cycle in which it is not granted.

Only the bench scenarios can show the points that depend on history and choice. These are:
- which cell wins when several requests are held;
- that the value on the bus is the winning cell's own identifier;
- that a request arriving together with an acknowledge is deferred to the next one;
- that a one-cycle device pulse is still served many cycles later.

// File: rtl/irq_chain_pkg.sv
// Package: shared sizing defaults and the per-cell identifier rule.
// Assumes identifiers are assigned densely upward from a base value.
package irq_chain_pkg;

    localparam int DEF_CELLS    = 8;
    localparam int DEF_VEC_W    = 8;
    localparam int DEF_VEC_BASE = 32;

    // Identifier returned by the cell at position idx.
    function automatic int cell_ident(input int base, input int idx);
        return base + idx;
    endfunction

endpackage

// File: rtl/irq_chain_cell.sv
// Module: one link of the acknowledge chain.
// Captures its device's request, forwards an acknowledge when idle and
// absorbs it when a request is held, driving its identifier while granted.
// Assumes ack_i is combinational from the cell ahead and valid before the edge.
module irq_chain_cell #(
    parameter int VW    = 8,
    parameter int IDENT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          ack_i,
    output logic          ack_o,
    output logic          grant_o,
    output logic          held_o,
    output logic [VW-1:0] vec_o
);

    localparam logic [VW-1:0] MY_VEC = VW'(IDENT);

    logic held_q;

    // Held request: set by the device, cleared by a grant, new request wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= 1'b0;
        else
            held_q <= (held_q && !grant_o) || req_i;
    end

    // Absorb or forward the acknowledge and drive the identifier when granted.
    always_comb begin
        grant_o = ack_i && held_q;
        ack_o   = ack_i && !held_q;
        vec_o   = grant_o ? MY_VEC : '0;
    end

    assign held_o = held_q;

    // R2: a grant only ever happens under an incoming acknowledge.
    assert_grant_needs_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> ack_i);

    // R6: a held request that is not granted survives to the next cycle.
    assert_held_survives_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && !grant_o) |=> held_q);

    // R7: a grant without a fresh request empties the cell.
    assert_grant_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && !req_i) |=> !held_q);

    // R8: a request seen together with a grant remains held afterwards.
    assert_new_req_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && req_i) |=> held_q);

endmodule

// File: rtl/irq_vec_bus.sv
// Module: shared vector bus merge.
// Each cell drives zero unless granted, so the bus is an OR across cells.
// Assumes at most one driver is non-zero in any cycle.
module irq_vec_bus #(
    parameter int N  = 8,
    parameter int VW = 8
) (
    input  logic [N-1:0][VW-1:0] drv_i,
    input  logic [N-1:0]         grant_i,
    output logic [VW-1:0]        bus_o,
    output logic                 valid_o
);

    logic [N:0][VW-1:0] acc;

    assign acc[0] = '0;

    // OR each cell's contribution into a running accumulator.
    for (genvar g = 0; g < N; g++) begin : g_merge
        assign acc[g+1] = acc[g] | drv_i[g];
    end

    // Present the merged bus and whether any cell is driving it.
    always_comb begin
        bus_o   = acc[N];
        valid_o = |grant_i;
    end

    // R4: an idle bus is zero.
    always_comb begin
        if (!valid_o)
            assert_idle_bus_zero_R4: assert (bus_o == '0);
    end

endmodule

// File: rtl/irq_chain.sv
// Module: top of the daisy-chained vectored interrupt responder.
// Builds N cells, threads the acknowledge through them in index order,
// ORs held requests onto one request line and merges the vector bus.
// Assumes int_ack is high for one cycle per acknowledge and is synchronous.
module irq_chain
    import irq_chain_pkg::*;
#(
    parameter int N        = DEF_CELLS,
    parameter int VW       = DEF_VEC_W,
    parameter int VEC_BASE = DEF_VEC_BASE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  dev_req,
    input  logic          int_ack,
    output logic          irq,
    output logic [VW-1:0] vec_out,
    output logic          vec_valid,
    output logic [N-1:0]  dev_granted,
    output logic          ack_tail
);

    logic [N:0]          ack_link;
    logic [N-1:0]        held;
    logic [N-1:0][VW-1:0] cell_vec;

    assign ack_link[0] = int_ack;

    // One cell per position; position sets priority.
    for (genvar g = 0; g < N; g++) begin : g_cell
        irq_chain_cell #(
            .VW    (VW),
            .IDENT (cell_ident(VEC_BASE, g))
        ) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (dev_req[g]),
            .ack_i   (ack_link[g]),
            .ack_o   (ack_link[g+1]),
            .grant_o (dev_granted[g]),
            .held_o  (held[g]),
            .vec_o   (cell_vec[g])
        );
    end

    irq_vec_bus #(
        .N  (N),
        .VW (VW)
    ) u_bus (
        .drv_i   (cell_vec),
        .grant_i (dev_granted),
        .bus_o   (vec_out),
        .valid_o (vec_valid)
    );

    // Shared request line and the unclaimed acknowledge at the chain end.
    always_comb begin
        irq      = |held;
        ack_tail = ack_link[N];
    end

    // R10: never more than one cell granted.
    assert_single_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_granted));

    // R4: the bus is never driven without an acknowledge.
    assert_no_drive_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !int_ack |-> (!vec_valid && vec_out == '0));

    // R5: an acknowledge reaches the tail only when no request is raised.
    assert_tail_when_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_tail |-> (int_ack && !irq));

    // R2: an acknowledge while a request is raised is always absorbed.
    assert_ack_absorbed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && irq) |-> (vec_valid && !ack_tail));

endmodule

// File: tb/sim_irq_chain.sv
// Bench: behavioural model of held requests compared every cycle.
module sim_irq_chain;

    localparam int N    = 8;
    localparam int VW   = 8;
    localparam int BASE = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  dev_req = '0;
    logic          int_ack = 1'b0;
    logic          irq;
    logic [VW-1:0] vec_out;
    logic          vec_valid;
    logic [N-1:0]  dev_granted;
    logic          ack_tail;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    bit model_pend [N];

    always #4 clk = ~clk;

    irq_chain #(.N(N), .VW(VW), .VEC_BASE(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .int_ack(int_ack),
        .irq(irq), .vec_out(vec_out), .vec_valid(vec_valid),
        .dev_granted(dev_granted), .ack_tail(ack_tail)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive inputs, compare against the model, advance the model.
    task automatic step(input logic [N-1:0] req, input bit ack, input string tag);
        int win;
        bit any;
        logic [N-1:0] exp_g;
        logic [VW-1:0] exp_v;
        dev_req = req;
        int_ack = ack;
        #2;
        any = 0;
        win = -1;
        for (int i = 0; i < N; i++) begin
            if (model_pend[i]) begin
                any = 1;
                if (win < 0) win = i;
            end
        end
        exp_g = '0;
        exp_v = '0;
        if (ack && win >= 0) begin
            exp_g[win] = 1'b1;
            exp_v = VW'(BASE + win);
        end
        check(irq == any, {tag, " R1"}, "irq", irq, any);
        check(dev_granted == exp_g, {tag, " R2 R10"}, "grant", dev_granted, exp_g);
        check(vec_out == exp_v, {tag, " R3 R4"}, "vec", vec_out, exp_v);
        check(vec_valid == (exp_g != 0), {tag, " R3 R4"}, "valid", vec_valid, exp_g != 0);
        check(ack_tail == (ack && !any), {tag, " R5"}, "tail", ack_tail, ack && !any);
        for (int i = 0; i < N; i++)
            model_pend[i] = (model_pend[i] && !exp_g[i]) || req[i];
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) model_pend[i] = 0;
        dev_req = '1;
        repeat (3) @(posedge clk);
        #1;
        // R9: reset clears everything despite requests during reset.
        check(irq == 0, "R9", "irq", irq, 0);
        check(vec_valid == 0 && vec_out == 0, "R9", "vec", vec_out, 0);
        check(dev_granted == 0, "R9", "grant", dev_granted, 0);
        dev_req = '0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        step('0, 1'b1, "R5 empty ack");
        // R6: single pulse on cell 3, held across idle cycles, then served.
        step(8'h08, 1'b0, "R6");
        repeat (5) step('0, 1'b0, "R6 hold");
        step('0, 1'b1, "R3 cell3");
        step('0, 1'b0, "R7 cleared");
        // R2: cells 1 and 5 together, served lowest first.
        step(8'h22, 1'b0, "R2");
        step('0, 1'b1, "R2 first");
        step('0, 1'b1, "R2 second");
        step('0, 1'b1, "R5 after drain");
        // R8: cell 4 held; cell 0 asks in the ack cycle and must wait.
        step(8'h10, 1'b0, "R8");
        step(8'h01, 1'b1, "R8 cell4 wins");
        step('0, 1'b1, "R8 cell0 next");
        // R7: granted cell re-requests in its grant cycle and stays held.
        step(8'h04, 1'b0, "R7");
        step(8'h04, 1'b1, "R7 rereq");
        step('0, 1'b0, "R7 still held");
        step('0, 1'b1, "R7 served again");
        // All cells, drained in index order.
        step('1, 1'b0, "R2 all");
        for (int k = 0; k < N + 1; k++) step('0, 1'b1, "R2 R3 drain");
        // Mixed traffic.
        for (int k = 0; k < 400; k++)
            step(N'($urandom) & N'($urandom), ($urandom % 3) == 0, "R1 R2 R10 mix");
        finish_run();
    end

endmodule